// File: doc/BRIEF.md
# ARINC Word Filter and Receive Queue

This block sits behind an ARINC 429 bit decoder. Each time the decoder finishes a 32-bit word it pulses a strobe with the word. The block then decides whether to keep the word. It can check the 8-bit label against a 256-entry enable table, check the two source/destination bits against programmed values, and optionally rewrite bit 32 as a parity-error marker. Words that pass are written into a 32-deep queue, which a host drains one word at a time.

The queue reports empty, half-full and full flags. A single interrupt flag shows either the empty flag or the full flag, chosen by a configuration bit. When the queue is full it does not drop new words: the newest stored entry is replaced. A master reset empties the queue. It leaves the configuration inputs and the label table alone.

The label table is maintained through a small command port with one-cycle operations: clear all, set all, clear one, set one, and load all 256 bits at once. The whole table is visible on a read-back bus.

Top module: `word_sieve`

## Requirements
- R1: With `cfg_label_en`=1 a strobed word is stored only if table bit `word_data[7:0]` is 1. With `cfg_label_en`=0 the table has no effect on storage.
- R2: With `cfg_sd_en`=1 a word is stored only if `word_data[9]` equals `cfg_sd_val[1]` and `word_data[8]` equals `cfg_sd_val[0]`.
- R3: When both checks are on, a word must pass both to be stored. When both are off, every strobed word is stored.
- R4: With `cfg_parity_en`=1, stored bit 31 is 0 if the 32 received bits hold an odd number of ones, and 1 if they hold an even number. Bits 30..0 are kept as received. With `cfg_parity_en`=0 the word is stored unchanged.
- R5: Stored words come out in arrival order. `rd_data` shows the oldest word, and `rd_en`=1 removes it at the clock edge.
- R6: A word stored while 32 words are held and `rd_en`=0 replaces the newest entry. The count stays at 32.
- R7: `st_empty`=1 when no word is held, `st_half`=1 when 16 or more are held, and `st_full`=1 when 32 are held. Each flag reflects the count after the most recent clock edge.
- R8: `irq_flag` equals `st_empty` when `cfg_flag_sel`=0 and equals `st_full` when `cfg_flag_sel`=1.
- R9: `mreset`=1 at an edge empties the queue and takes priority over a store in that cycle. It changes neither the label table nor the effect of the configuration inputs.
- R10: While the queue is empty `rd_data` is all zeros, and `rd_en` has no effect.
- R11: A strobed word that is discarded leaves `st_empty`, `st_half`, `st_full` and `rd_data` unchanged.
- R12: When 32 words are held and a store and a read happen in the same cycle, the oldest word is removed, the new word is appended, and the count stays at 32.
- R13: `tbl_op` codes act in one cycle:
  - 1 clears all bits;
  - 2 sets all bits;
  - 3 clears bit `tbl_addr`;
  - 4 sets bit `tbl_addr`;
  - 5 loads `tbl_load_data`;
  - 0, 6 and 7 leave the table unchanged.

  `tbl_rd_data[i]` is table bit i. A word strobed in the same cycle is filtered against the table as it stood before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset: empties the queue and clears the table |
| mreset | input | 1 | Synchronous master reset of the queue |
| cfg_label_en | input | 1 | Enable label recognition |
| cfg_sd_en | input | 1 | Enable source/destination bit match |
| cfg_sd_val | input | 2 | Required values of word bits 9 and 8 |
| cfg_parity_en | input | 1 | Replace bit 31 with a parity-error marker |
| cfg_flag_sel | input | 1 | Interrupt source: 0 selects empty, 1 selects full |
| word_valid | input | 1 | Completed-word strobe from the decoder |
| word_data | input | 32 | Completed word; bit 0 is ARINC bit 1 |
| rd_en | input | 1 | Remove the oldest word |
| rd_data | output | 32 | Oldest stored word, or zero when empty |
| tbl_op | input | 3 | Label table command |
| tbl_addr | input | 8 | Label index for single-bit commands |
| tbl_load_data | input | 256 | Full table image for the load command |
| tbl_rd_data | output | 256 | Current table contents |
| st_empty | output | 1 | Queue empty |
| st_half | output | 1 | Queue holds 16 or more words |
| st_full | output | 1 | Queue holds 32 words |
| irq_flag | output | 1 | Selected status flag |

## Verification
The bench builds the block with its default depth of 32. With that depth, the half-full threshold and the overwrite-on-full path are reached after a few dozen directed stores. The random phase passes through them repeatedly, with reads, discards, table commands and master resets mixed in. Because the label field is a fixed 8 bits, all 256 table entries are in play. Random labels are drawn from a narrow range so that table commands and lookups collide often.

// File: rtl/wsv_pkg.sv
package wsv_pkg;
    localparam int WORD_W = 32;
    localparam int LBL_W  = 8;
    localparam int NUM_LBL = 1 << LBL_W;

    typedef enum logic [2:0] {
        TBL_NOP     = 3'd0,
        TBL_CLR_ALL = 3'd1,
        TBL_SET_ALL = 3'd2,
        TBL_CLR_ONE = 3'd3,
        TBL_SET_ONE = 3'd4,
        TBL_LOAD    = 3'd5
    } tbl_op_e;

    typedef struct packed {
        logic       label_en;
        logic       sd_en;
        logic [1:0] sd_val;
        logic       parity_en;
        logic       flag_sel;
    } cfg_t;
endpackage

// File: rtl/wsv_label_table.sv
module wsv_label_table
    import wsv_pkg::*;
#(
    parameter int NUM = NUM_LBL,
    localparam int AW = $clog2(NUM)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  tbl_op_e        op,
    input  logic [AW-1:0]  addr,
    input  logic [NUM-1:0] load_data,
    output logic [NUM-1:0] bits
);
    typedef struct packed {
        logic [NUM-1:0] bits;
    } tbl_st_t;

    tbl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (op)
            TBL_CLR_ALL: st_d.bits = '0;
            TBL_SET_ALL: st_d.bits = '1;
            TBL_CLR_ONE: st_d.bits[addr] = 1'b0;
            TBL_SET_ONE: st_d.bits[addr] = 1'b1;
            TBL_LOAD:    st_d.bits = load_data;
            default:     st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits = st_q.bits;

    // R13
    label_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == TBL_SET_ONE) |=> bits[$past(addr)]);
    // R13
    label_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == TBL_CLR_ONE) |=> !bits[$past(addr)]);
endmodule

// File: rtl/wsv_accept.sv
module wsv_accept
    import wsv_pkg::*;
(
    input  cfg_t              cfg,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    input  logic              label_hit,
    output logic              accept,
    output logic [WORD_W-1:0] stored
);
    logic label_ok, sd_ok;

    always_comb begin
        label_ok = !cfg.label_en || label_hit;
        sd_ok    = !cfg.sd_en || (word[LBL_W+1:LBL_W] == cfg.sd_val);
        accept   = word_valid && label_ok && sd_ok;
        stored   = word;
        if (cfg.parity_en) stored[WORD_W-1] = ~^word;
    end
endmodule

// File: rtl/wsv_fifo.sv
module wsv_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         half,
    output logic         full
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [W-1:0]  mem_q [DEPTH];
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic          is_full, is_empty, pop, push_new;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
        return (p == '0) ? AW'(DEPTH - 1) : p - AW'(1);
    endfunction

    always_comb begin
        st_d     = st_q;
        is_full  = (st_q.cnt == CW'(DEPTH));
        is_empty = (st_q.cnt == '0);
        pop      = rd && !is_empty && !clr;
        push_new = wr && !clr && (!is_full || pop);
        mem_we   = wr && !clr;
        mem_addr = st_q.wptr;
        if (clr) begin
            st_d = '0;
        end else begin
            if (wr && is_full && !pop) mem_addr = ptr_dec(st_q.wptr);
            if (push_new) st_d.wptr = ptr_inc(st_q.wptr);
            if (pop)      st_d.rptr = ptr_inc(st_q.rptr);
            st_d.cnt = st_q.cnt + CW'(push_new) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem_q[mem_addr] <= wdata;
    end

    assign rdata = is_empty ? '0 : mem_q[st_q.rptr];
    assign empty = is_empty;
    assign full  = is_full;
    assign half  = (st_q.cnt >= CW'(DEPTH / 2));

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    // R6
    overwrite_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !rd && !clr) |=> (full && $stable(st_q.rptr)));
    // R12
    full_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && rd && !clr) |=> full);
    // R9
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);
    // R10
    empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd && !wr && !clr) |=> (empty && rdata == '0));
endmodule

// File: rtl/word_sieve.sv
module word_sieve
    import wsv_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mreset,
    input  logic                cfg_label_en,
    input  logic                cfg_sd_en,
    input  logic [1:0]          cfg_sd_val,
    input  logic                cfg_parity_en,
    input  logic                cfg_flag_sel,
    input  logic                word_valid,
    input  logic [WORD_W-1:0]   word_data,
    input  logic                rd_en,
    output logic [WORD_W-1:0]   rd_data,
    input  logic [2:0]          tbl_op,
    input  logic [LBL_W-1:0]    tbl_addr,
    input  logic [NUM_LBL-1:0]  tbl_load_data,
    output logic [NUM_LBL-1:0]  tbl_rd_data,
    output logic                st_empty,
    output logic                st_half,
    output logic                st_full,
    output logic                irq_flag
);
    cfg_t              cfg;
    logic [NUM_LBL-1:0] tbl_bits;
    logic              wr_acc;
    logic [WORD_W-1:0] wr_word;

    always_comb begin
        cfg.label_en  = cfg_label_en;
        cfg.sd_en     = cfg_sd_en;
        cfg.sd_val    = cfg_sd_val;
        cfg.parity_en = cfg_parity_en;
        cfg.flag_sel  = cfg_flag_sel;
    end

    wsv_label_table #(.NUM(NUM_LBL)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (tbl_op_e'(tbl_op)),
        .addr      (tbl_addr),
        .load_data (tbl_load_data),
        .bits      (tbl_bits)
    );

    wsv_accept u_accept (
        .cfg        (cfg),
        .word_valid (word_valid),
        .word       (word_data),
        .label_hit  (tbl_bits[word_data[LBL_W-1:0]]),
        .accept     (wr_acc),
        .stored     (wr_word)
    );

    wsv_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mreset),
        .wr    (wr_acc),
        .wdata (wr_word),
        .rd    (rd_en),
        .rdata (rd_data),
        .empty (st_empty),
        .half  (st_half),
        .full  (st_full)
    );

    assign tbl_rd_data = tbl_bits;
    assign irq_flag    = cfg.flag_sel ? st_full : st_empty;

    // R1
    label_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && cfg_label_en) |-> tbl_rd_data[word_data[LBL_W-1:0]]);
    // R2
    sd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && cfg_sd_en) |-> (word_data[LBL_W+1:LBL_W] == cfg_sd_val));
    // R3
    all_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !cfg_label_en && !cfg_sd_en) |-> wr_acc);
    // R4
    parity_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && cfg_parity_en) |-> (wr_word[WORD_W-1] == ~^word_data));
    // R11
    discard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !wr_acc && !rd_en && !mreset)
        |=> ($stable({st_empty, st_half, st_full}) && $stable(rd_data)));
endmodule

// File: tb/word_sieve_tb.sv
module word_sieve_tb;
    localparam int DEPTH = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mreset = 1'b0;
    logic         cfg_label_en = 1'b0, cfg_sd_en = 1'b0, cfg_parity_en = 1'b0, cfg_flag_sel = 1'b0;
    logic [1:0]   cfg_sd_val = 2'b00;
    logic         word_valid = 1'b0;
    logic [31:0]  word_data = '0;
    logic         rd_en = 1'b0;
    logic [31:0]  rd_data;
    logic [2:0]   tbl_op = 3'd0;
    logic [7:0]   tbl_addr = '0;
    logic [255:0] tbl_load_data = '0;
    logic [255:0] tbl_rd_data;
    logic         st_empty, st_half, st_full, irq_flag;

    int total = 0;
    int bad = 0;
    string ph = "R7";
    logic [31:0]  q[$];
    logic [255:0] tbl = '0;
    bit done = 0;

    always #10 clk = ~clk;

    word_sieve #(.DEPTH(DEPTH)) u_dut (
        .clk, .rst_n, .mreset, .cfg_label_en, .cfg_sd_en, .cfg_sd_val,
        .cfg_parity_en, .cfg_flag_sel, .word_valid, .word_data, .rd_en,
        .rd_data, .tbl_op, .tbl_addr, .tbl_load_data, .tbl_rd_data,
        .st_empty, .st_half, .st_full, .irq_flag
    );

    function automatic bit f_accept(input logic [31:0] w);
        bit ok = 1;
        if (cfg_label_en && !tbl[w[7:0]]) ok = 0;
        if (cfg_sd_en && (w[9] != cfg_sd_val[1] || w[8] != cfg_sd_val[0])) ok = 0;
        return ok;
    endfunction

    function automatic logic [31:0] f_store(input logic [31:0] w);
        int ones = $countones(w);
        logic [31:0] r = w;
        if (cfg_parity_en) r[31] = (ones % 2 == 1) ? 1'b0 : 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] mkw(input logic [7:0] lbl, input logic [1:0] sd,
                                        input logic [20:0] body, input logic top);
        return {top, body, sd, lbl};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        word_valid = 0; rd_en = 0; mreset = 0; tbl_op = 3'd0;
    endtask

    task automatic model_update();
        bit acc;
        bit do_rd;
        logic [31:0] sv;
        acc = word_valid && f_accept(word_data);
        sv = f_store(word_data);
        do_rd = rd_en && (q.size() > 0);
        if (mreset) q.delete();
        else begin
            if (do_rd) void'(q.pop_front());
            if (acc) begin
                if (q.size() == DEPTH) q[$] = sv;
                else q.push_back(sv);
            end
        end
        case (tbl_op)
            3'd1: tbl = '0;
            3'd2: tbl = '1;
            3'd3: tbl[tbl_addr] = 1'b0;
            3'd4: tbl[tbl_addr] = 1'b1;
            3'd5: tbl = tbl_load_data;
            default: ;
        endcase
    endtask

    task automatic compare();
        logic [31:0] eh;
        logic ee, eh2, ef;
        eh  = (q.size() > 0) ? q[0] : 32'h0;
        ee  = (q.size() == 0);
        eh2 = (q.size() >= DEPTH / 2);
        ef  = (q.size() == DEPTH);
        chk(rd_data === eh, ph, rd_data, eh);
        chk(st_empty === ee, "R7 empty", st_empty, ee);
        chk(st_half === eh2, "R7 half", st_half, eh2);
        chk(st_full === ef, "R7 full", st_full, ef);
        chk(irq_flag === (cfg_flag_sel ? ef : ee), "R8", irq_flag, cfg_flag_sel ? ef : ee);
        chk(tbl_rd_data === tbl, "R13", tbl_rd_data, tbl);
    endtask

    task automatic tick();
        model_update();
        @(posedge clk);
        @(negedge clk);
        compare();
        idle();
    endtask

    task automatic put(input logic [31:0] w);
        word_valid = 1; word_data = w; tick();
    endtask

    task automatic drain();
        while (q.size() > 0) begin rd_en = 1; tick(); end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        ph = "R7"; compare();                 // reset state
        ph = "R10"; rd_en = 1; tick();         // read on empty: zeros, no effect
        chk(rd_data == 0, "R10", rd_data, 0);

        // R13: table commands
        ph = "R13";
        tbl_op = 3'd2; tick();
        tbl_op = 3'd3; tbl_addr = 8'h35; tick();
        tbl_op = 3'd6; tbl_addr = 8'h36; tick();

        // R1: label recognition
        ph = "R1"; cfg_label_en = 1;
        put(mkw(8'h35, 2'b00, 21'h1234, 1'b0));    // rejected, R11 flags stay
        chk(st_empty == 1, "R11", st_empty, 1);
        put(mkw(8'h36, 2'b00, 21'h0abc, 1'b1));    // accepted
        drain();

        // R2: source/destination match
        ph = "R2"; cfg_label_en = 0; cfg_sd_en = 1; cfg_sd_val = 2'b10;
        put(mkw(8'h35, 2'b10, 21'h0001, 1'b0));
        put(mkw(8'h35, 2'b01, 21'h0002, 1'b0));    // rejected
        drain();

        // R3: both checks
        ph = "R3"; cfg_label_en = 1;
        put(mkw(8'h35, 2'b10, 21'h0003, 1'b0));    // label fails
        put(mkw(8'h40, 2'b11, 21'h0004, 1'b0));    // sd fails
        put(mkw(8'h40, 2'b10, 21'h0005, 1'b0));    // both pass
        cfg_label_en = 0; cfg_sd_en = 0;
        put(mkw(8'h35, 2'b01, 21'h0006, 1'b0));    // neither on
        drain();

        // R4: parity marker
        ph = "R4"; cfg_parity_en = 1;
        put(32'h0000_0001);    // odd ones -> bit31 0
        put(32'h8000_0001);    // even -> bit31 1
        put(32'h0000_0003);    // even -> 1
        cfg_parity_en = 0;
        put(32'h8000_0001);    // unchanged
        drain();

        // R6, R12: full behaviour
        ph = "R5"; cfg_flag_sel = 1;
        for (int i = 0; i < DEPTH; i++) put(32'h100 + i);
        ph = "R6";
        put(32'hDEAD_0001);
        put(32'hDEAD_0002);
        ph = "R12";
        word_valid = 1; word_data = 32'hBEEF_0001; rd_en = 1; tick();

        // R9: master reset keeps configuration and table
        ph = "R9"; cfg_label_en = 1;
        mreset = 1; word_valid = 1; word_data = mkw(8'h40, 2'b00, 21'h7, 1'b0); tick();
        chk(st_empty == 1 && irq_flag == 0, "R9", {st_empty, irq_flag}, 2'b10);
        put(mkw(8'h35, 2'b00, 21'h9, 1'b0));      // still filtered
        chk(st_empty == 1, "R9", st_empty, 1);
        cfg_label_en = 0;

        // random phase
        ph = "R5";
        void'($urandom(32'h5eed_0429));
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 3) begin
                cfg_label_en = $urandom; cfg_sd_en = $urandom; cfg_sd_val = 2'($urandom);
                cfg_parity_en = $urandom; cfg_flag_sel = $urandom;
            end
            word_valid = ($urandom_range(0, 99) < 55);
            word_data = $urandom;
            word_data[7:0] = 8'($urandom_range(0, 7));
            rd_en = ($urandom_range(0, 99) < 40);
            mreset = ($urandom_range(0, 499) == 0);
            r = $urandom_range(0, 99);
            if (r < 8) begin
                tbl_op = 3'($urandom_range(0, 7));
                tbl_addr = 8'($urandom_range(0, 7));
                tbl_load_data = {$urandom, $urandom, $urandom, $urandom,
                                 $urandom, $urandom, $urandom, $urandom};
            end
            tick();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog R5 act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule